// File: doc/BRIEF.md
# Text-mode character cell buffer

This block holds the contents of a text screen as a grid of character cells and lets a host change it through a single memory-mapped bus. Each cell takes two consecutive words: the even word holds the character code and the odd word after it holds that character's attribute. With the default grid of 30 columns by 18 rows, cell k = row*30 + col sits at words 2k and 2k+1, so video memory spans addresses 0 to 1079. A second, read-only port lets a display scanner fetch any word without disturbing the host.

Near the top of the 2048-word address space sit a few control words. Three plain registers hold the default background colour, the cursor position and the cursor enable. Four command addresses start bulk operations: clear one row, clear one column, clear the whole screen, or scroll the image by a signed number of rows. An internal sequencer runs each operation one word per cycle. `busy` is high while it runs, so the host never copies data itself.

The sequencer has six states. SQ_IDLE waits for a command. SQ_CLR_ROW, SQ_CLR_COL and SQ_CLR_ALL write zeros. SQ_SCR_DN walks the words from the last to the first and copies each from n rows above. SQ_SCR_UP walks from the first word to the last and copies each from n rows below. In both scroll states a word whose source falls off the grid is zeroed. A valid command accepted in SQ_IDLE moves the machine to its operation state. Each operation state stays put while its word count is non-zero and returns to SQ_IDLE after writing its last word.

Top module: `text_cell_buffer`

## Requirements
- R1: After reset every video word, the background colour, the cursor position and the cursor enable read 0, and `busy` is low.
- R2: A host write to an address 0..1079 stores the word. Even address 2k holds the character code of cell k and 2k+1 its attribute, where k = row*30 + col. A read presents the word on `bus_rdata` one cycle after the address is applied.
- R3: `scan_data` shows the video word at `scan_addr` (0..1079) one cycle after the address is applied.
- R4: Addresses 1080..2030 and the unassigned control addresses (2031..2037, 2043, 2044, 2047) read 0, and writes to them change nothing. The command addresses 2038..2041 also read 0.
- R5: Address 2042 holds the background colour (16 bits). Address 2045 holds the cursor position (bits 10:0; the upper read bits are 0). Address 2046 holds the cursor enable (bit 0; the upper read bits are 0). All three read back what was written.
- R6: Writing r < 18 to address 2039 zeroes both words of every cell in row r (words 60r..60r+59). A value r of 18 or more starts nothing.
- R7: Writing c < 30 to address 2040 zeroes words 60r+2c and 60r+2c+1 for every row r. A value c of 30 or more starts nothing.
- R8: Writing any value to address 2041 zeroes all 1080 video words.
- R9: Writing n (a 16-bit two's complement value) to address 2038 scrolls the image. After the scroll, row r holds old row r-n. Rows with no source are zeroed, so a positive n moves the image down and a negative n moves it up. If |n| is 18 or more the screen is cleared. n = 0 starts nothing.
- R10: While `busy` is high, host writes to video memory and to the command addresses are dropped. Writes to the colour and cursor registers are still taken.
- R11: `busy` rises in the cycle after an accepted command write and stays high for exactly 60 cycles (row), 36 (column), 1080 (screen) or 1080 (scroll).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Host word address |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, one cycle after the address |
| busy | output | 1 | A bulk operation is running |
| scan_addr | input | 11 | Scanner word address |
| scan_data | output | 16 | Scanner read data, one cycle after the address |

## Verification
Both read ports and the control registers answer one clock after the address; a bulk command's effect completes, and `busy` falls, exactly 60, 36 or 1080 cycles after the edge that accepted it. The bench's reference model takes each write at the same edge as the design, predicts the read results from its state before that edge, and counts down its own busy length, so every comparison lands in the cycle the result is due. Video reads and scan results sampled while an operation is still under way are skipped, because the intermediate memory contents are not specified. The busy length of every command, and its absence for ignored values, is counted cycle by cycle against the figure in R11.

// File: rtl/txtbuf_pkg.sv
package txtbuf_pkg;

    // control word map (upper end of the address space)
    localparam int CTRL_LO_ADDR = 2031;
    localparam int SCROLL_ADDR  = 2038;
    localparam int CLR_ROW_ADDR = 2039;
    localparam int CLR_COL_ADDR = 2040;
    localparam int CLR_ALL_ADDR = 2041;
    localparam int BG_ADDR      = 2042;
    localparam int CUR_POS_ADDR = 2045;
    localparam int CUR_EN_ADDR  = 2046;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLR_ROW,
        SQ_CLR_COL,
        SQ_CLR_ALL,
        SQ_SCR_DN,
        SQ_SCR_UP
    } seq_state_e;

endpackage

// File: rtl/txtbuf_store.sv
module txtbuf_store #(
    parameter int DW    = 16,
    parameter int AW    = 11,
    parameter int WORDS = 1080
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] seq_raddr,
    output logic [DW-1:0] seq_rdata,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_data
);

    localparam logic [AW-1:0] LIMIT = AW'(WORDS);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we && (waddr < LIMIT)) begin
            mem[waddr] <= wdata;
        end
    end

    assign host_rdata = (host_raddr < LIMIT) ? mem[host_raddr] : '0;
    assign seq_rdata  = (seq_raddr  < LIMIT) ? mem[seq_raddr]  : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  scan_data <= '0;
        else if (scan_addr < LIMIT)  scan_data <= mem[scan_addr];
        else                         scan_data <= '0;
    end

endmodule

// File: rtl/txtbuf_regs.sv
module txtbuf_regs
    import txtbuf_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] bg_q;
    logic [AW-1:0] cpos_q;
    logic          cen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q   <= '0;
            cpos_q <= '0;
            cen_q  <= 1'b0;
        end else if (we) begin
            case (addr)
                AW'(BG_ADDR):      bg_q   <= wdata;
                AW'(CUR_POS_ADDR): cpos_q <= wdata[AW-1:0];
                AW'(CUR_EN_ADDR):  cen_q  <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            AW'(BG_ADDR):      rdata = bg_q;
            AW'(CUR_POS_ADDR): rdata = DW'(cpos_q);
            AW'(CUR_EN_ADDR):  rdata = DW'(cen_q);
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/txtbuf_seq.sv
module txtbuf_seq
    import txtbuf_pkg::*;
#(
    parameter int COLS = 30,
    parameter int ROWS = 18,
    parameter int DW   = 16,
    parameter int AW   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_row,
    input  logic          go_col,
    input  logic          go_all,
    input  logic          go_scroll,
    input  logic [DW-1:0] arg,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata
);

    localparam int ROW_WORDS = 2 * COLS;
    localparam int WORDS     = ROW_WORDS * ROWS;
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;
    logic [AW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] shift_q, shift_d;

    // command argument decode
    logic          row_ok, col_ok;
    logic [AW-1:0] row_base, col_base;
    logic [DW:0]   mag;
    logic [AW-1:0] rows_sh, shift_words;
    logic [AW:0]   src_up;

    assign row_ok      = arg < DW'(ROWS);
    assign col_ok      = arg < DW'(COLS);
    assign row_base    = AW'(arg) * AW'(ROW_WORDS);
    assign col_base    = AW'(arg) + AW'(arg);
    assign mag         = arg[DW-1] ? ((DW+1)'(0) - {1'b1, arg}) : {1'b0, arg};
    assign rows_sh     = (mag >= (DW+1)'(ROWS)) ? AW'(ROWS) : AW'(mag);
    assign shift_words = rows_sh * AW'(ROW_WORDS);
    assign src_up      = {1'b0, idx_q} + {1'b0, shift_q};

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (go_all) begin
                    state_d = SQ_CLR_ALL;
                    idx_d   = '0;
                    cnt_d   = LAST;
                end else if (go_row && row_ok) begin
                    state_d = SQ_CLR_ROW;
                    idx_d   = row_base;
                    cnt_d   = AW'(ROW_WORDS - 1);
                end else if (go_col && col_ok) begin
                    state_d = SQ_CLR_COL;
                    idx_d   = col_base;
                    cnt_d   = AW'(2 * ROWS - 1);
                end else if (go_scroll && (arg != '0)) begin
                    shift_d = shift_words;
                    cnt_d   = LAST;
                    if (arg[DW-1]) begin
                        state_d = SQ_SCR_UP;
                        idx_d   = '0;
                    end else begin
                        state_d = SQ_SCR_DN;
                        idx_d   = LAST;
                    end
                end
            end
            default: begin
                if (cnt_q == '0) state_d = SQ_IDLE;
                else             cnt_d   = cnt_q - AW'(1);
                if (state_q == SQ_SCR_DN)
                    idx_d = idx_q - AW'(1);
                else if (state_q == SQ_CLR_COL)
                    idx_d = idx_q[0] ? idx_q + AW'(ROW_WORDS - 1) : idx_q + AW'(1);
                else
                    idx_d = idx_q + AW'(1);
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != SQ_IDLE);
        mem_we    = busy;
        mem_waddr = idx_q;
        mem_raddr = idx_q;
        mem_wdata = '0;
        unique case (state_q)
            SQ_SCR_DN: begin
                mem_raddr = idx_q - shift_q;
                mem_wdata = (idx_q < shift_q) ? '0 : mem_rdata;
            end
            SQ_SCR_UP: begin
                mem_raddr = src_up[AW-1:0];
                mem_wdata = (src_up >= (AW+1)'(WORDS)) ? '0 : mem_rdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/text_cell_buffer.sv
module text_cell_buffer
    import txtbuf_pkg::*;
#(
    parameter int COLS = 30,
    parameter int ROWS = 18,
    parameter int DW   = 16,
    parameter int AW   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          busy,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_data
);

    localparam int ROW_WORDS = 2 * COLS;
    localparam int WORDS     = ROW_WORDS * ROWS;

    logic          hit_video, accept;
    logic          go_row, go_col, go_all, go_scroll;
    logic          seq_we;
    logic [AW-1:0] seq_waddr, seq_raddr;
    logic [DW-1:0] seq_wdata, seq_rdata;
    logic          st_we;
    logic [AW-1:0] st_waddr;
    logic [DW-1:0] st_wdata;
    logic [DW-1:0] vid_rd, reg_rd;

    assign hit_video = bus_addr < AW'(WORDS);
    assign accept    = bus_we && !busy;
    assign go_row    = accept && (bus_addr == AW'(CLR_ROW_ADDR));
    assign go_col    = accept && (bus_addr == AW'(CLR_COL_ADDR));
    assign go_all    = accept && (bus_addr == AW'(CLR_ALL_ADDR));
    assign go_scroll = accept && (bus_addr == AW'(SCROLL_ADDR));

    txtbuf_seq #(.COLS(COLS), .ROWS(ROWS), .DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_row    (go_row),
        .go_col    (go_col),
        .go_all    (go_all),
        .go_scroll (go_scroll),
        .arg       (bus_wdata),
        .busy      (busy),
        .mem_we    (seq_we),
        .mem_waddr (seq_waddr),
        .mem_wdata (seq_wdata),
        .mem_raddr (seq_raddr),
        .mem_rdata (seq_rdata)
    );

    // the sequencer owns the write port while it runs
    assign st_we    = seq_we || (accept && hit_video);
    assign st_waddr = seq_we ? seq_waddr : bus_addr;
    assign st_wdata = seq_we ? seq_wdata : bus_wdata;

    txtbuf_store #(.DW(DW), .AW(AW), .WORDS(WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (st_we),
        .waddr      (st_waddr),
        .wdata      (st_wdata),
        .host_raddr (bus_addr),
        .host_rdata (vid_rd),
        .seq_raddr  (seq_raddr),
        .seq_rdata  (seq_rdata),
        .scan_addr  (scan_addr),
        .scan_data  (scan_data)
    );

    txtbuf_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (reg_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= hit_video ? vid_rd : reg_rd;
    end

endmodule

// File: rtl/text_cell_buffer_chk.sv
module text_cell_buffer_chk
    import txtbuf_pkg::*;
#(
    parameter int COLS = 30,
    parameter int ROWS = 18,
    parameter int DW   = 16,
    parameter int AW   = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          busy
);

    localparam int WORDS = 2 * COLS * ROWS;

    AST_CLR_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_addr == AW'(CLR_ALL_ADDR)) |=> busy); // R11

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= AW'(WORDS) && bus_addr < AW'(CTRL_LO_ADDR)) |=> (bus_rdata == '0)); // R4

    AST_BAD_ROW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_addr == AW'(CLR_ROW_ADDR) && bus_wdata >= DW'(ROWS)) |=> !busy); // R6

    AST_BAD_COL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_addr == AW'(CLR_COL_ADDR) && bus_wdata >= DW'(COLS)) |=> !busy); // R7

    AST_ZERO_SCROLL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_addr == AW'(SCROLL_ADDR) && bus_wdata == '0) |=> !busy); // R9

    AST_CUR_EN_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(CUR_EN_ADDR)) |=> (bus_rdata[DW-1:1] == '0)); // R5

endmodule

bind text_cell_buffer text_cell_buffer_chk #(
    .COLS(COLS), .ROWS(ROWS), .DW(DW), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy)
);

// File: tb/text_cell_buffer_tb.sv
`timescale 1ns/1ps
module text_cell_buffer_tb;

    localparam int COLS  = 30;
    localparam int ROWS  = 18;
    localparam int RW    = 60;
    localparam int WORDS = 1080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        busy;
    logic [10:0] scan_addr = '0;
    logic [15:0] scan_data;

    always #10 clk = ~clk;   // 50 MHz

    text_cell_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .scan_addr(scan_addr), .scan_data(scan_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model
    int    m_mem [WORDS];
    int    m_bg, m_cpos, m_cen, m_busy;
    int    exp_rd, exp_sc;
    bit    rd_ok, sc_ok, armed;
    string rd_tag;

    function automatic void check(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endfunction

    function automatic int m_read(int a);
        if (a < WORDS) return m_mem[a];
        if (a == 2042) return m_bg;
        if (a == 2045) return m_cpos;
        if (a == 2046) return m_cen;
        return 0;
    endfunction

    function automatic void m_scroll(int n);
        int tmp [WORDS];
        for (int r = 0; r < ROWS; r++)
            for (int w = 0; w < RW; w++) begin
                int src = r - n;
                tmp[r*RW + w] = (src >= 0 && src < ROWS) ? m_mem[src*RW + w] : 0;
            end
        for (int i = 0; i < WORDS; i++) m_mem[i] = tmp[i];
    endfunction

    function automatic void m_command(int a, int d);
        if (a < WORDS) m_mem[a] = d;
        else if (a == 2039 && d < ROWS) begin
            for (int w = 0; w < RW; w++) m_mem[d*RW + w] = 0;
            m_busy = RW;
        end else if (a == 2040 && d < COLS) begin
            for (int r = 0; r < ROWS; r++) begin
                m_mem[r*RW + 2*d] = 0;
                m_mem[r*RW + 2*d + 1] = 0;
            end
            m_busy = 2 * ROWS;
        end else if (a == 2041) begin
            for (int i = 0; i < WORDS; i++) m_mem[i] = 0;
            m_busy = WORDS;
        end else if (a == 2038 && d != 0) begin
            m_scroll((d >= 32768) ? d - 65536 : d);
            m_busy = WORDS;
        end
    endfunction

    always @(posedge clk) begin
        int a, d, s;
        a = int'(bus_addr);
        d = int'(bus_wdata);
        s = int'(scan_addr);
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) m_mem[i] = 0;
            m_bg = 0; m_cpos = 0; m_cen = 0; m_busy = 0; armed = 0;
        end else begin
            exp_rd = m_read(a);
            rd_ok  = !(m_busy > 0 && a < WORDS);
            if (tag == "R1")                      rd_tag = "R1";
            else if (a < WORDS)                   rd_tag = tag;
            else if (a == 2042 || a == 2045 || a == 2046) rd_tag = "R5";
            else                                  rd_tag = "R4";
            exp_sc = (s < WORDS) ? m_mem[s] : 0;
            sc_ok  = (m_busy == 0);
            armed  = 1;
            if (bus_we) begin
                if (a == 2042)      m_bg   = d;
                else if (a == 2045) m_cpos = d & 16'h07FF;
                else if (a == 2046) m_cen  = d & 1;
            end
            if (m_busy > 0)  m_busy--;
            else if (bus_we) m_command(a, d);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && armed && !done) begin
            check("R11 busy", int'(busy), (m_busy > 0) ? 1 : 0);
            if (rd_ok) check(rd_tag, int'(bus_rdata), exp_rd);
            if (sc_ok) check("R3 scan", int'(scan_data), exp_sc);
        end
    end

    // scanner sweeps the whole video area
    initial begin
        forever begin
            @(negedge clk);
            #1;
            scan_addr = 11'((int'(scan_addr) + 7) % WORDS);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = 16'(d);
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = 11'(a);
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int a = lo; a <= hi; a++) rd(a);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // issue a command and count the cycles busy stays high (R11)
    task automatic run_cmd(input int a, input int d, input int exp_n, input string t);
        int n = 0;
        wr(a, d);
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check({t, " R11 busy length"}, n, exp_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        tag = "R1";
        check("R1 busy after reset", int'(busy), 0);
        rd(0); rd(1); rd(1079); rd(2042); rd(2045); rd(2046);

        // R2: fill and read back video memory
        tag = "R2";
        for (int a = 0; a < WORDS; a++) wr(a, (a * 37 + 11) & 16'hFFFF);
        sweep(0, WORDS - 1);

        // R4: reserved and unassigned words
        tag = "R4";
        wr(1500, 16'h1234); rd(1500);
        wr(2035, 9);        rd(2035);
        wr(2044, 5);        rd(2044);
        wr(1080, 77);       rd(1080); rd(2030); rd(2039); rd(2047);
        sweep(0, 3);

        // R5: colour and cursor registers
        tag = "R5";
        wr(2042, 16'hABCD);
        wr(2045, 16'hF123);
        wr(2046, 16'hFFFE); rd(2046);
        wr(2046, 3);
        rd(2042); rd(2045); rd(2046);

        // R6: row clear, valid and out of range
        tag = "R6";
        run_cmd(2039, 3, 60, "R6");
        sweep(2 * RW, 5 * RW - 1);
        run_cmd(2039, 18, 0, "R6");
        rd(3 * RW + 8);

        // R7: column clear, valid and out of range
        tag = "R7";
        run_cmd(2040, 29, 36, "R7");
        sweep(0, WORDS - 1);
        run_cmd(2040, 30, 0, "R7");

        // R9: scroll down, up, zero, oversize
        tag = "R9";
        run_cmd(2038, 2, 1080, "R9");
        sweep(0, WORDS - 1);
        run_cmd(2038, 16'hFFFD, 1080, "R9");
        sweep(0, WORDS - 1);
        run_cmd(2038, 0, 0, "R9");
        run_cmd(2038, 40, 1080, "R9");
        sweep(0, 2 * RW);

        // R10: writes while busy
        tag = "R10";
        for (int w = 0; w < 2 * RW; w++) wr(5 * RW + w, w + 100);
        wr(2039, 5);
        check("R10 busy after row command", int'(busy), 1);
        wr(5 * RW + 4, 16'h5555);
        wr(2041, 1);
        wr(2042, 16'h0077);
        wait_idle();
        repeat (3) @(negedge clk);
        check("R10 dropped clear-all starts nothing", int'(busy), 0);
        rd(5 * RW + 4);
        sweep(5 * RW, 7 * RW - 1);
        rd(2042);

        // R8: full clear
        tag = "R8";
        run_cmd(2041, 0, 1080, "R8");
        sweep(0, WORDS - 1);
        rd(2042);
        rd(2045);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule